// File: doc/BRIEF.md
# Priority-Ratio Memory Request Scheduler

This block sits between the last-level cache and a memory channel. It holds up to sixteen pending memory accesses (line fills after a miss and dirty-line writebacks alike), each tagged with one of two priority levels, and each cycle it offers one of them to the memory side. Memory accepts the offered request with a ready/valid handshake.

Bandwidth is divided between the two levels by a run-time bypass degree N. High-priority requests may overtake older low-priority ones, but once N high-priority requests have been issued while low-priority work was waiting, the oldest low-priority request is issued next. This gives roughly an N:1 split under contention. The controller can change N while traffic flows. With the scheme switched off, or with N set to zero, the block is a plain first-in first-out queue. Two counters record the number of accesses issued at each level.

Top module: `prio_ratio_sched`

## Requirements
- R1: After reset the queue is empty: `iss_valid` is 0, `enq_ready` is 1 and both issue counters read 0.
- R2: When `cfg_en` is 0, or `cfg_degree` is 0, requests are issued strictly in arrival order, whatever their levels.
- R3: With the scheme active (`cfg_en`=1, `cfg_degree`=N>0), the oldest high-priority request (`prio`=0) is issued ahead of older low-priority requests (`prio`=1), as long as fewer than N high-priority requests have been issued since the last low-priority issue.
- R4: With the scheme active, once N high-priority requests have been issued while a low-priority request was pending, the next issue is the oldest pending low-priority request.
- R5: Within one priority level, requests are issued oldest first.
- R6: A high-priority request that is issued while no low-priority request is pending does not count towards N. With no low-priority work pending, high-priority requests are issued without limit.
- R7: The bypass count returns to zero each time a low-priority request is issued. It is also held at zero while the scheme is inactive.
- R8: The queue holds 16 entries. While it is full, `enq_ready` is 0, and an enqueue attempt is dropped: it never appears at the issue port.
- R9: `cnt_hi` and `cnt_lo` each increase by one for every issued request of their level, reads and writebacks alike. The flag `wr` (1 = writeback) travels unchanged with its address.
- R10: A new `cfg_degree` written at run time governs the very next issue decision.
- R11: `iss_valid` is 1 exactly when the queue is not empty. Without `iss_ready`, nothing is removed and neither counter moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Enqueue request present |
| enq_ready | output | 1 | Queue has room |
| enq_prio | input | 1 | Level of new request: 0 high, 1 low |
| enq_wr | input | 1 | 1 = writeback, 0 = miss fill read |
| enq_addr | input | ADDR_W | Line address |
| cfg_en | input | 1 | Enable ratio scheme |
| cfg_degree | input | DEG_W | Bypass degree N |
| iss_valid | output | 1 | A request is offered to memory |
| iss_ready | input | 1 | Memory accepts the offered request |
| iss_prio | output | 1 | Level of offered request |
| iss_wr | output | 1 | Write flag of offered request |
| iss_addr | output | ADDR_W | Address of offered request |
| cnt_hi | output | CNT_W | Issued high-priority accesses |
| cnt_lo | output | CNT_W | Issued low-priority accesses |

## Verification
An enqueue and an issue can fall in the same clock edge. The queue then compacts its entries and writes the newcomer in a single step, so the newcomer must land one slot lower than the occupancy alone would suggest. The bench provokes this by holding `iss_ready` high and pushing a new request on every cycle. It judges the result by checking that each request appears at the issue port exactly one cycle after its enqueue edge, in arrival order, with nothing lost or duplicated. The full-queue case is also run back to back, to confirm that a refused enqueue leaves no trace.

// File: rtl/prs_pkg.sv
// Shared types for the priority-ratio scheduler.
// Assumes two priority levels; level code 0 is the favoured one.
package prs_pkg;
    localparam int NUM_LEVELS = 2;

    typedef enum logic {
        LVL_HI = 1'b0,
        LVL_LO = 1'b1
    } lvl_e;

    typedef enum logic [1:0] {
        PICK_HEAD = 2'd0,
        PICK_HI   = 2'd1,
        PICK_LO   = 2'd2
    } pick_e;
endpackage

// File: rtl/prs_queue.sv
// Age-ordered request store. Slot 0 always holds the oldest entry.
// Removing slot k shifts every younger entry down by one.
// A push lands at the tail, which is corrected for a removal in the same cycle.
// Assumes the caller never pushes when full and never pops when empty.
module prs_queue
    import prs_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int OCC_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  lvl_e              push_lvl,
    input  logic              push_wr,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    input  logic [IDX_W-1:0]  pop_idx,
    output logic [OCC_W-1:0]  occ,
    output logic [DEPTH-1:0]  vld,
    output lvl_e              lvl_q  [DEPTH],
    output logic              wr_q   [DEPTH],
    output logic [ADDR_W-1:0] addr_q [DEPTH]
);
    lvl_e              lvl_n  [DEPTH];
    logic              wr_n   [DEPTH];
    logic [ADDR_W-1:0] addr_n [DEPTH];
    logic [OCC_W-1:0]  tail;

    // Valid bits follow the occupancy: slots below occ are live.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vld[i] = (OCC_W'(i) < occ);
        end
    end

    // Tail slot for a push, one lower when an entry leaves this cycle.
    assign tail = occ - OCC_W'(pop);

    // Next contents: compact over the removed slot, then write the newcomer.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            lvl_n[i]  = lvl_q[i];
            wr_n[i]   = wr_q[i];
            addr_n[i] = addr_q[i];
        end
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= pop_idx) begin
                    lvl_n[i]  = lvl_q[i+1];
                    wr_n[i]   = wr_q[i+1];
                    addr_n[i] = addr_q[i+1];
                end
            end
        end
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (OCC_W'(i) == tail) begin
                    lvl_n[i]  = push_lvl;
                    wr_n[i]   = push_wr;
                    addr_n[i] = push_addr;
                end
            end
        end
    end

    // Occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            occ <= occ + OCC_W'(push) - OCC_W'(pop);
        end
    end

    // Entry storage; contents of empty slots are don't-care.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                lvl_q[i]  <= LVL_HI;
                wr_q[i]   <= 1'b0;
                addr_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                lvl_q[i]  <= lvl_n[i];
                wr_q[i]   <= wr_n[i];
                addr_q[i] <= addr_n[i];
            end
        end
    end
endmodule

// File: rtl/prs_pick.sv
// Finds the oldest live entry of each level by scanning from slot 0 upward.
// Purely combinational. Assumes slot order equals age order.
module prs_pick
    import prs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] vld,
    input  lvl_e             lvl_q [DEPTH],
    output logic             hi_any,
    output logic             lo_any,
    output logic [IDX_W-1:0] hi_idx,
    output logic [IDX_W-1:0] lo_idx
);
    logic [DEPTH-1:0] hi_vec;
    logic [DEPTH-1:0] lo_vec;

    // Split the live entries by level.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_split
            assign hi_vec[g] = vld[g] && (lvl_q[g] == LVL_HI);
            assign lo_vec[g] = vld[g] && (lvl_q[g] == LVL_LO);
        end
    endgenerate

    assign hi_any = |hi_vec;
    assign lo_any = |lo_vec;

    // Lowest set bit wins: scan from the top so the last hit is the oldest.
    always_comb begin
        hi_idx = '0;
        lo_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hi_vec[i]) hi_idx = IDX_W'(i);
            if (lo_vec[i]) lo_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/prs_ratio.sv
// Bypass-degree policy. Chooses which entry to offer and keeps the count of
// high-priority issues made while low-priority work waited.
// Assumes fire is asserted only when a request actually leaves.
module prs_ratio
    import prs_pkg::*;
#(
    parameter int DEG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [DEG_W-1:0] cfg_degree,
    input  logic             hi_any,
    input  logic             lo_any,
    input  logic             fire,
    input  lvl_e             fire_lvl,
    output pick_e            pick
);
    localparam logic [DEG_W-1:0] BYP_MAX = '1;

    logic             active;
    logic [DEG_W-1:0] byp_cnt;

    assign active = cfg_en && (cfg_degree != '0);

    // Decide the source of the next issue.
    always_comb begin
        if (!active) begin
            pick = PICK_HEAD;
        end else if (lo_any && (!hi_any || byp_cnt >= cfg_degree)) begin
            pick = PICK_LO;
        end else begin
            pick = PICK_HI;
        end
    end

    // Bypass counter: counts only real overtakes, clears on a low issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_cnt <= '0;
        end else if (!active) begin
            byp_cnt <= '0;
        end else if (fire && fire_lvl == LVL_LO) begin
            byp_cnt <= '0;
        end else if (fire && lo_any && byp_cnt != BYP_MAX) begin
            byp_cnt <= byp_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/prs_tally.sv
// One wrapping access counter per priority level.
// Assumes at most one issue per cycle.
module prs_tally
    import prs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  lvl_e             fire_lvl,
    output logic [CNT_W-1:0] cnt [NUM_LEVELS]
);
    generate
        for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
            // Count issues that carry this level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt[g] <= '0;
                end else if (fire && fire_lvl == lvl_e'(g)) begin
                    cnt[g] <= cnt[g] + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/prio_ratio_sched.sv
// Top of the priority-ratio memory request scheduler.
// Holds pending fills and writebacks, offers one per cycle to memory, and
// lets up to cfg_degree high-priority requests pass waiting low ones.
// Assumes the memory side takes the offer only on iss_valid && iss_ready.
module prio_ratio_sched
    import prs_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int DEG_W  = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic              enq_prio,
    input  logic              enq_wr,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic              cfg_en,
    input  logic [DEG_W-1:0]  cfg_degree,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic              iss_prio,
    output logic              iss_wr,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [CNT_W-1:0]  cnt_hi,
    output logic [CNT_W-1:0]  cnt_lo
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [OCC_W-1:0]  occ;
    logic [DEPTH-1:0]  vld;
    lvl_e              lvl_q  [DEPTH];
    logic              wr_q   [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic              hi_any;
    logic              lo_any;
    logic [IDX_W-1:0]  hi_idx;
    logic [IDX_W-1:0]  lo_idx;
    logic [IDX_W-1:0]  sel_idx;
    pick_e             pick;
    logic              push;
    logic              fire;
    lvl_e              sel_lvl;
    logic [CNT_W-1:0]  cnt [NUM_LEVELS];

    assign enq_ready = (occ != OCC_W'(DEPTH));
    assign push      = enq_valid && enq_ready;
    assign iss_valid = (occ != '0);
    assign fire      = iss_valid && iss_ready;

    // Map the policy choice to a slot index.
    always_comb begin
        case (pick)
            PICK_HI: sel_idx = hi_idx;
            PICK_LO: sel_idx = lo_idx;
            default: sel_idx = '0;
        endcase
    end

    assign sel_lvl  = lvl_q[sel_idx];
    assign iss_prio = sel_lvl;
    assign iss_wr   = wr_q[sel_idx];
    assign iss_addr = addr_q[sel_idx];
    assign cnt_hi   = cnt[0];
    assign cnt_lo   = cnt[1];

    prs_queue #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W),
        .OCC_W (OCC_W)
    ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_lvl (lvl_e'(enq_prio)),
        .push_wr  (enq_wr),
        .push_addr(enq_addr),
        .pop      (fire),
        .pop_idx  (sel_idx),
        .occ      (occ),
        .vld      (vld),
        .lvl_q    (lvl_q),
        .wr_q     (wr_q),
        .addr_q   (addr_q)
    );

    prs_pick #(
        .DEPTH(DEPTH),
        .IDX_W(IDX_W)
    ) u_pick (
        .vld   (vld),
        .lvl_q (lvl_q),
        .hi_any(hi_any),
        .lo_any(lo_any),
        .hi_idx(hi_idx),
        .lo_idx(lo_idx)
    );

    prs_ratio #(
        .DEG_W(DEG_W)
    ) u_ratio (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_degree(cfg_degree),
        .hi_any    (hi_any),
        .lo_any    (lo_any),
        .fire      (fire),
        .fire_lvl  (sel_lvl),
        .pick      (pick)
    );

    prs_tally #(
        .CNT_W(CNT_W)
    ) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .fire_lvl(sel_lvl),
        .cnt     (cnt)
    );
endmodule

// File: rtl/prio_ratio_sched_chk.sv
// Port-level checker for the scheduler. Keeps its own occupancy and bypass
// model from the handshakes and compares it with the outputs.
module prio_ratio_sched_chk #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int DEG_W  = 4,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enq_valid,
    input logic              enq_ready,
    input logic              enq_prio,
    input logic              cfg_en,
    input logic [DEG_W-1:0]  cfg_degree,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic              iss_prio,
    input logic [CNT_W-1:0]  cnt_hi,
    input logic [CNT_W-1:0]  cnt_lo
);
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [OCC_W-1:0] occ_m;
    logic [OCC_W-1:0] lo_m;
    logic [DEG_W-1:0] byp_m;
    logic             in_f;
    logic             out_f;
    logic             act_m;

    assign in_f  = enq_valid && enq_ready;
    assign out_f = iss_valid && iss_ready;
    assign act_m = cfg_en && (cfg_degree != '0);

    // Track total and low-level occupancy from the two handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_m <= '0;
            lo_m  <= '0;
        end else begin
            occ_m <= occ_m + OCC_W'(in_f) - OCC_W'(out_f);
            lo_m  <= lo_m + OCC_W'(in_f && enq_prio) - OCC_W'(out_f && iss_prio);
        end
    end

    // Model of overtakes since the last low-priority issue.
    always_ff @(posedge clk) begin
        if (!rst_n || !act_m) begin
            byp_m <= '0;
        end else if (out_f && iss_prio) begin
            byp_m <= '0;
        end else if (out_f && lo_m != '0 && byp_m != '1) begin
            byp_m <= byp_m + 1'b1;
        end
    end

    a_r8_ready_tracks_room: assert property (@(posedge clk) disable iff (!rst_n)
        enq_ready == (occ_m < OCC_W'(DEPTH)));

    a_r11_valid_tracks_fill: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid == (occ_m != '0));

    a_r9_hi_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_f && !iss_prio) |=> (cnt_hi == $past(cnt_hi) + 1'b1) && $stable(cnt_lo));

    a_r9_lo_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_f && iss_prio) |=> (cnt_lo == $past(cnt_lo) + 1'b1) && $stable(cnt_hi));

    a_r11_idle_counters: assert property (@(posedge clk) disable iff (!rst_n)
        !out_f |=> $stable(cnt_hi) && $stable(cnt_lo));

    a_r4_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
        (act_m && iss_valid && lo_m != '0 && byp_m >= cfg_degree) |-> iss_prio);

    a_r6_high_when_no_low: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && lo_m == '0) |-> !iss_prio);
endmodule

bind prio_ratio_sched prio_ratio_sched_chk #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .DEG_W (DEG_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_valid (enq_valid),
    .enq_ready (enq_ready),
    .enq_prio  (enq_prio),
    .cfg_en    (cfg_en),
    .cfg_degree(cfg_degree),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_prio  (iss_prio),
    .cnt_hi    (cnt_hi),
    .cnt_lo    (cnt_lo)
);

// File: tb/prio_ratio_sched_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module prio_ratio_sched_tb;
    localparam int ADDR_W = 32;
    localparam int DEG_W  = 4;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              enq_valid;
    logic              enq_ready;
    logic              enq_prio;
    logic              enq_wr;
    logic [ADDR_W-1:0] enq_addr;
    logic              cfg_en;
    logic [DEG_W-1:0]  cfg_degree;
    logic              iss_valid;
    logic              iss_ready;
    logic              iss_prio;
    logic              iss_wr;
    logic [ADDR_W-1:0] iss_addr;
    logic [CNT_W-1:0]  cnt_hi;
    logic [CNT_W-1:0]  cnt_lo;

    int checks = 0;
    int errors = 0;
    int exp_hi = 0;
    int exp_lo = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    prio_ratio_sched u_dut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_prio(enq_prio),
        .enq_wr(enq_wr), .enq_addr(enq_addr),
        .cfg_en(cfg_en), .cfg_degree(cfg_degree),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_prio(iss_prio),
        .iss_wr(iss_wr), .iss_addr(iss_addr),
        .cnt_hi(cnt_hi), .cnt_lo(cnt_lo)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic p, input logic w, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        enq_valid = 1'b1; enq_prio = p; enq_wr = w; enq_addr = a;
        @(posedge clk);
        #1 enq_valid = 1'b0;
    endtask

    task automatic pop_chk(input logic p, input logic w, input logic [ADDR_W-1:0] a,
                           input string req);
        @(negedge clk);
        chk(iss_valid && iss_prio == p && iss_wr == w && iss_addr == a, req,
            "issued {valid,prio,wr,addr}",
            {iss_valid, iss_prio, iss_wr, iss_addr}, {1'b1, p, w, a});
        if (p) exp_lo++; else exp_hi++;
        iss_ready = 1'b1;
        @(posedge clk);
        #1 iss_ready = 1'b0;
    endtask

    task automatic chk_counts(input string req);
        @(negedge clk);
        chk(cnt_hi == CNT_W'(exp_hi), req, "cnt_hi", cnt_hi, exp_hi);
        chk(cnt_lo == CNT_W'(exp_lo), req, "cnt_lo", cnt_lo, exp_lo);
    endtask

    task automatic chk_empty(input string req);
        @(negedge clk);
        chk(!iss_valid, req, "iss_valid when empty", iss_valid, 0);
    endtask

    // R1: reset state.
    task automatic t_reset;
        @(negedge clk);
        chk(!iss_valid, "R1", "iss_valid", iss_valid, 0);
        chk(enq_ready, "R1", "enq_ready", enq_ready, 1);
        chk(cnt_hi == 0 && cnt_lo == 0, "R1", "counters", {cnt_hi, cnt_lo}, 0);
    endtask

    // R2: arrival order when disabled, and when degree is zero.
    task automatic t_fifo;
        cfg_en = 1'b0; cfg_degree = 4'd3;
        push(1, 0, 32'h100); push(0, 1, 32'h101); push(1, 1, 32'h102); push(0, 0, 32'h103);
        pop_chk(1, 0, 32'h100, "R2"); pop_chk(0, 1, 32'h101, "R2");
        pop_chk(1, 1, 32'h102, "R2"); pop_chk(0, 0, 32'h103, "R2");
        cfg_en = 1'b1; cfg_degree = 4'd0;
        push(1, 0, 32'h110); push(0, 0, 32'h111);
        pop_chk(1, 0, 32'h110, "R2"); pop_chk(0, 0, 32'h111, "R2");
        chk_empty("R2");
    endtask

    // R3 R4 R5 R7: degree 2 with two lows waiting.
    task automatic t_bypass;
        cfg_en = 1'b1; cfg_degree = 4'd2;
        push(1, 0, 32'h200); push(1, 1, 32'h201);
        push(0, 0, 32'h202); push(0, 1, 32'h203); push(0, 0, 32'h204); push(0, 0, 32'h205);
        pop_chk(0, 0, 32'h202, "R3"); pop_chk(0, 1, 32'h203, "R3");
        pop_chk(1, 0, 32'h200, "R4");
        pop_chk(0, 0, 32'h204, "R7"); pop_chk(0, 0, 32'h205, "R7");
        pop_chk(1, 1, 32'h201, "R5");
        chk_counts("R9");
    endtask

    // R6: highs alone do not use up the allowance.
    task automatic t_no_low;
        cfg_en = 1'b1; cfg_degree = 4'd2;
        for (int k = 0; k < 5; k++) push(0, 0, 32'h300 + k);
        for (int k = 0; k < 5; k++) pop_chk(0, 0, 32'h300 + k, "R6");
        push(1, 0, 32'h310);
        push(0, 0, 32'h311); push(0, 0, 32'h312); push(0, 0, 32'h313);
        pop_chk(0, 0, 32'h311, "R6"); pop_chk(0, 0, 32'h312, "R6");
        pop_chk(1, 0, 32'h310, "R6"); pop_chk(0, 0, 32'h313, "R6");
    endtask

    // R10: degree changed between runs governs the next decision.
    task automatic t_runtime;
        cfg_en = 1'b1; cfg_degree = 4'd1;
        push(1, 0, 32'h400); push(1, 0, 32'h401);
        push(0, 0, 32'h402); push(0, 0, 32'h403); push(0, 0, 32'h404);
        pop_chk(0, 0, 32'h402, "R10"); pop_chk(1, 0, 32'h400, "R10");
        pop_chk(0, 0, 32'h403, "R10"); pop_chk(1, 0, 32'h401, "R10");
        pop_chk(0, 0, 32'h404, "R10");
        cfg_degree = 4'd3;
        push(1, 1, 32'h410);
        for (int k = 0; k < 4; k++) push(0, 0, 32'h411 + k);
        pop_chk(0, 0, 32'h411, "R10"); pop_chk(0, 0, 32'h412, "R10");
        pop_chk(0, 0, 32'h413, "R10"); pop_chk(1, 1, 32'h410, "R10");
        pop_chk(0, 0, 32'h414, "R10");
        chk_counts("R9");
    endtask

    // R8: fill sixteen, refused push leaves no trace.
    task automatic t_full;
        cfg_en = 1'b0;
        for (int k = 0; k < 16; k++) push(k[0], 0, 32'h500 + k);
        @(negedge clk);
        chk(!enq_ready, "R8", "enq_ready when full", enq_ready, 0);
        push(0, 0, 32'hDEAD);
        for (int k = 0; k < 16; k++) pop_chk(k[0], 0, 32'h500 + k, "R8");
        chk_empty("R8");
        @(negedge clk);
        chk(enq_ready, "R8", "enq_ready after drain", enq_ready, 1);
    endtask

    // R11: no ready, no removal, counters hold.
    task automatic t_stall;
        cfg_en = 1'b0;
        push(0, 1, 32'h600);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(iss_valid && iss_addr == 32'h600, "R11", "held offer",
            {iss_valid, iss_addr}, {1'b1, 32'h600});
        chk_counts("R11");
        pop_chk(0, 1, 32'h600, "R11");
        chk_empty("R11");
        chk_counts("R9");
    endtask

    // Concurrent enqueue and issue on every edge.
    task automatic t_stream;
        cfg_en = 1'b0;
        iss_ready = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k > 0) begin
                chk(iss_valid && iss_addr == 32'h700 + k - 1, "R5", "streamed addr",
                    {iss_valid, iss_addr}, {1'b1, 32'h700 + k - 1});
                exp_hi++;
            end
            enq_valid = 1'b1; enq_prio = 1'b0; enq_wr = 1'b0; enq_addr = 32'h700 + k;
            @(posedge clk);
        end
        @(negedge clk);
        enq_valid = 1'b0;
        chk(iss_valid && iss_addr == 32'h705, "R5", "streamed last",
            {iss_valid, iss_addr}, {1'b1, 32'h705});
        exp_hi++;
        @(posedge clk);
        #1 iss_ready = 1'b0;
        chk_empty("R11");
        chk_counts("R9");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; enq_valid = 1'b0; enq_prio = 1'b0; enq_wr = 1'b0;
        enq_addr = '0; cfg_en = 1'b0; cfg_degree = '0; iss_ready = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fifo();
        t_bypass();
        t_no_low();
        t_runtime();
        t_full();
        t_stall();
        t_stream();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule